// File: doc/BRIEF.md
# Shared Capture Memory Arbiter

This block lets a sampling front end and a host processor take turns on a single byte-wide memory. Each byte from the converter is written at the address held in an internal capture pointer. The pointer steps up by one after every completed capture write, so a run of samples fills consecutive locations. The processor brings its own address, write data and write flag, and raises a request that it holds until its access has been served.

At any moment at most one master owns the memory buses. The owner's address and data are routed to the memory controller, and a matching enable pair tells the surrounding logic which master is driving. Ownership changes only when the memory controller reports the current access finished with `mem_ack`. A converter byte that arrives while the memory is busy waits in a one-deep holding register. A processor request raised during a capture write is granted as soon as that write completes. The memory controller's own timing lies outside this block: it sees a steady bus and answers with one acknowledge per access.

Top module: `dpm_arbiter`

## Requirements
- R1: Reset is synchronous and active high. After reset both enables are low, `cap_addr` is 0, `mem_we` is 0, and `mem_addr` and `mem_wdata` are 0.
- R2: The 16-bit capture pointer `cap_addr` rises by exactly one in the cycle after each `mem_ack` seen while `cap_en` is high, and it wraps from 0xFFFF to 0x0000. In all other cycles it holds its value, except when it is cleared.
- R3: `cap_en` and `cpu_en` are never high in the same cycle.
- R4: Once an access has begun, its enable stays high until a cycle in which `mem_ack` is high. Ownership changes only after such a cycle.
- R5: While `cap_en` is high, `mem_addr` equals `cap_addr`, `mem_wdata` is the stored converter byte, and `mem_we` is 1. While `cpu_en` is high, `mem_addr`, `mem_wdata` and `mem_we` follow `cpu_addr`, `cpu_wdata` and `cpu_we`. With no owner, all three are 0.
- R6: `cap_clear` forces `cap_addr` to 0 in the next cycle, and it takes precedence over an increment in the same cycle.
- R7: If `cpu_req` is high in the cycle where a capture write is acknowledged, `cpu_en` is high in the next cycle, even if another converter byte is waiting.
- R8: A `cap_valid` strobe stores `cap_byte`. With the memory idle, the capture write begins (`cap_en` high) in the second cycle after the strobe. When a processor access is acknowledged while a byte is waiting, the waiting capture goes next. From idle, a waiting byte wins over a processor request.
- R9: `mem_ack` while no master owns the memory has no effect: both enables stay low and `cap_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_clear | input | 1 | Clears the capture pointer before a run |
| cap_valid | input | 1 | Converter byte valid strobe |
| cap_byte | input | 8 | Converter byte |
| cpu_req | input | 1 | Processor request, held until served |
| cpu_we | input | 1 | Processor write flag (1 = write) |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| mem_ack | input | 1 | Memory controller: current access complete |
| mem_addr | output | 16 | Address to memory controller |
| mem_wdata | output | 8 | Write data to memory controller |
| mem_we | output | 1 | Write enable to memory controller |
| cap_en | output | 1 | Capture path drives the buses |
| cpu_en | output | 1 | Processor drives the buses |
| cap_addr | output | 16 | Current capture pointer |

## Verification
The properties assume two things about the inputs. The processor keeps `cpu_req`, `cpu_addr`, `cpu_wdata` and `cpu_we` steady from the moment it raises the request until its access is acknowledged. The converter never strobes a new byte while an earlier byte is still waiting. The random stimulus respects both rules: it holds the processor fields stable until the acknowledge and drops the request right after it, and it raises `cap_valid` only when its own model has no byte waiting. `mem_ack` is left free, so it also arrives during idle cycles. A long back-to-back capture burst drives the pointer through its wrap.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    localparam int ADDR_W_DEF = 16;
    localparam int DATA_W_DEF = 8;
    localparam int STAGE_W    = 4;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_CAP  = 2'd1,
        OWN_CPU  = 2'd2
    } owner_e;

    // Picks the owner of the next cycle. A busy owner keeps the bus until done.
    function automatic owner_e pick_owner(owner_e cur, logic done,
                                          logic cpu_req, logic cap_wait);
        owner_e nxt;
        nxt = cur;
        unique case (cur)
            OWN_NONE: begin
                if (cap_wait)     nxt = OWN_CAP;
                else if (cpu_req) nxt = OWN_CPU;
            end
            OWN_CAP: if (done) begin
                if (cpu_req)       nxt = OWN_CPU;
                else if (cap_wait) nxt = OWN_CAP;
                else               nxt = OWN_NONE;
            end
            OWN_CPU: if (done) begin
                if (cap_wait)     nxt = OWN_CAP;
                else if (cpu_req) nxt = OWN_CPU;
                else              nxt = OWN_NONE;
            end
            default: nxt = OWN_NONE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/dpm_cap_counter.sv
module dpm_cap_counter #(
    parameter int ADDR_W  = dpm_pkg::ADDR_W_DEF,
    parameter int STAGE_W = dpm_pkg::STAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] count
);
    localparam int N_STG = ADDR_W / STAGE_W;

    logic [N_STG:0] carry;
    assign carry[0] = inc;

    // Cascaded nibble stages; each advances when all lower stages roll over.
    for (genvar g = 0; g < N_STG; g++) begin : g_stage
        logic [STAGE_W-1:0] nib;

        assign carry[g+1] = carry[g] & (&nib);

        always_ff @(posedge clk) begin
            if (rst || clr)
                nib <= '0;
            else if (carry[g])
                nib <= nib + STAGE_W'(1);
        end

        assign count[g*STAGE_W +: STAGE_W] = nib;
    end

endmodule

// File: rtl/dpm_owner_fsm.sv
module dpm_owner_fsm
    import dpm_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_valid,
    input  logic [DATA_W-1:0] cap_byte,
    input  logic              cpu_req,
    input  logic              mem_ack,
    output owner_e            owner,
    output logic [DATA_W-1:0] act_byte,
    output logic              cap_step
);
    owner_e            owner_q, owner_d;
    logic              wait_q;
    logic [DATA_W-1:0] wait_byte_q;
    logic [DATA_W-1:0] act_byte_q;
    logic              load_cap;

    always_comb begin
        owner_d  = pick_owner(owner_q, mem_ack, cpu_req, wait_q);
        load_cap = (owner_d == OWN_CAP) && ((owner_q != OWN_CAP) || mem_ack);
        cap_step = (owner_q == OWN_CAP) && mem_ack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q     <= OWN_NONE;
            wait_q      <= 1'b0;
            wait_byte_q <= '0;
            act_byte_q  <= '0;
        end else begin
            owner_q <= owner_d;
            if (load_cap)
                act_byte_q <= wait_byte_q;
            if (cap_valid) begin
                wait_q      <= 1'b1;
                wait_byte_q <= cap_byte;
            end else if (load_cap) begin
                wait_q <= 1'b0;
            end
        end
    end

    assign owner    = owner_q;
    assign act_byte = act_byte_q;

endmodule

// File: rtl/dpm_bus_mux.sv
module dpm_bus_mux
    import dpm_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  owner_e            owner,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [DATA_W-1:0] cap_data,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              cap_en,
    output logic              cpu_en
);
    always_comb begin
        cap_en    = (owner == OWN_CAP);
        cpu_en    = (owner == OWN_CPU);
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        if (cap_en) begin
            mem_addr  = cap_addr;
            mem_wdata = cap_data;
            mem_we    = 1'b1;
        end else if (cpu_en) begin
            mem_addr  = cpu_addr;
            mem_wdata = cpu_data;
            mem_we    = cpu_we;
        end
    end

endmodule

// File: rtl/dpm_arbiter.sv
module dpm_arbiter
    import dpm_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_clear,
    input  logic              cap_valid,
    input  logic [DATA_W-1:0] cap_byte,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              cap_en,
    output logic              cpu_en,
    output logic [ADDR_W-1:0] cap_addr
);
    owner_e            owner;
    logic [DATA_W-1:0] act_byte;
    logic              cap_step;

    dpm_owner_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cap_valid (cap_valid),
        .cap_byte  (cap_byte),
        .cpu_req   (cpu_req),
        .mem_ack   (mem_ack),
        .owner     (owner),
        .act_byte  (act_byte),
        .cap_step  (cap_step)
    );

    dpm_cap_counter #(.ADDR_W(ADDR_W), .STAGE_W(STAGE_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cap_clear),
        .inc   (cap_step),
        .count (cap_addr)
    );

    dpm_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .owner     (owner),
        .cap_addr  (cap_addr),
        .cap_data  (act_byte),
        .cpu_addr  (cpu_addr),
        .cpu_data  (cpu_wdata),
        .cpu_we    (cpu_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .cap_en    (cap_en),
        .cpu_en    (cpu_en)
    );

endmodule

// File: rtl/dpm_arbiter_chk.sv
module dpm_arbiter_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cap_clear,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic              cap_en,
    input logic              cpu_en,
    input logic [ADDR_W-1:0] cap_addr
);
    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
        !(cap_en && cpu_en)); // R3
    AST_CAP_HELD: assert property (@(posedge clk) disable iff (rst)
        cap_en && !mem_ack |=> cap_en); // R4
    AST_CPU_HELD: assert property (@(posedge clk) disable iff (rst)
        cpu_en && !mem_ack |=> cpu_en); // R4
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        cap_en && mem_ack && !cap_clear |=> (cap_addr - $past(cap_addr)) == ADDR_W'(1)); // R2
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cap_en && mem_ack) && !cap_clear |=> $stable(cap_addr)); // R9
    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cap_clear |=> cap_addr == '0); // R6
    AST_CPU_AFTER_CAP: assert property (@(posedge clk) disable iff (rst)
        cap_en && mem_ack && cpu_req |=> cpu_en); // R7
    AST_CAP_BUS: assert property (@(posedge clk) disable iff (rst)
        cap_en |-> (mem_addr == cap_addr) && mem_we); // R5
    AST_CPU_BUS: assert property (@(posedge clk) disable iff (rst)
        cpu_en |-> (mem_addr == cpu_addr) && (mem_wdata == cpu_wdata) && (mem_we == cpu_we)); // R5
    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
        !cap_en && !cpu_en |-> !mem_we && (mem_addr == '0)); // R5

endmodule

bind dpm_arbiter dpm_arbiter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_dpm_arbiter.sv
`timescale 1ns/1ps
module test_dpm_arbiter;

    logic        clk = 1'b0;
    logic        rst;
    logic        cap_clear, cap_valid, cpu_req, cpu_we, mem_ack;
    logic [7:0]  cap_byte, cpu_wdata, mem_wdata;
    logic [15:0] cpu_addr, mem_addr, cap_addr;
    logic        mem_we, cap_en, cpu_en;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model: 0 idle, 1 capture, 2 processor
    int          m_st;
    logic [15:0] m_cnt;
    logic        m_wait;
    logic [7:0]  m_wbyte, m_abyte;
    logic        cpu_drop;

    always #2.5 clk = ~clk;

    dpm_arbiter i_dpm_arbiter (
        .clk(clk), .rst(rst), .cap_clear(cap_clear), .cap_valid(cap_valid),
        .cap_byte(cap_byte), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .mem_ack(mem_ack),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .cap_en(cap_en), .cpu_en(cpu_en), .cap_addr(cap_addr)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_addr();
        return (m_st == 1) ? m_cnt : (m_st == 2) ? cpu_addr : 16'h0;
    endfunction
    function automatic logic [7:0] exp_wdata();
        return (m_st == 1) ? m_abyte : (m_st == 2) ? cpu_wdata : 8'h0;
    endfunction
    function automatic logic exp_we();
        return (m_st == 1) ? 1'b1 : (m_st == 2) ? cpu_we : 1'b0;
    endfunction

    function automatic int next_st(int st, logic ack, logic req, logic wt);
        if (st == 0) return wt ? 1 : (req ? 2 : 0);
        if (!ack) return st;
        if (st == 1) return req ? 2 : (wt ? 1 : 0);
        return wt ? 1 : (req ? 2 : 0);
    endfunction

    // Compare outputs, apply the next inputs, advance the model to the next edge.
    task automatic step(logic v, logic [7:0] b, logic rq, logic we,
                        logic [15:0] a, logic [7:0] d, logic ak, logic cl);
        int  ns;
        logic ld;
        @(negedge clk);
        chk("R3", {31'd0, cap_en & cpu_en}, 32'd0);
        chk("R4 cap_en", {31'd0, cap_en}, {31'd0, m_st == 1});
        chk("R4 cpu_en", {31'd0, cpu_en}, {31'd0, m_st == 2});
        chk("R2 cap_addr", {16'd0, cap_addr}, {16'd0, m_cnt});
        chk("R5 mem_addr", {16'd0, mem_addr}, {16'd0, exp_addr()});
        chk("R5 mem_wdata", {24'd0, mem_wdata}, {24'd0, exp_wdata()});
        chk("R5 mem_we", {31'd0, mem_we}, {31'd0, exp_we()});
        cap_valid = v; cap_byte = b; cpu_req = rq; cpu_we = we;
        cpu_addr = a; cpu_wdata = d; mem_ack = ak; cap_clear = cl;
        ns = next_st(m_st, ak, rq, m_wait);
        ld = (ns == 1) && ((m_st != 1) || ak);
        cpu_drop = (m_st == 2) && ak;
        if (cl) m_cnt = 16'h0;
        else if (m_st == 1 && ak) m_cnt = m_cnt + 16'h1;
        if (ld) m_abyte = m_wbyte;
        if (v) begin m_wait = 1'b1; m_wbyte = b; end
        else if (ld) m_wait = 1'b0;
        m_st = ns;
    endtask

    task automatic idle(logic ak);
        step(1'b0, 8'h0, 1'b0, 1'b0, 16'h0, 8'h0, ak, 1'b0);
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        logic        rq;
        logic        rwe;
        logic [15:0] ra;
        logic [7:0]  rd;
        void'($urandom(32'h5eed_1234));
        rst = 1'b1;
        cap_clear = 0; cap_valid = 0; cap_byte = 0; cpu_req = 0; cpu_we = 0;
        cpu_addr = 0; cpu_wdata = 0; mem_ack = 0;
        m_st = 0; m_cnt = 0; m_wait = 0; m_wbyte = 0; m_abyte = 0; cpu_drop = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state right after reset
        chk("R1 cap_en", {31'd0, cap_en}, 32'd0);
        chk("R1 cpu_en", {31'd0, cpu_en}, 32'd0);
        chk("R1 cap_addr", {16'd0, cap_addr}, 32'd0);
        chk("R1 mem_we", {31'd0, mem_we}, 32'd0);
        chk("R1 mem_addr", {16'd0, mem_addr}, 32'd0);

        // R9: acknowledges with no owner do nothing
        repeat (4) idle(1'b1);
        idle(1'b0);
        chk("R9 cap_addr", {16'd0, cap_addr}, 32'd0);
        chk("R9 enables", {30'd0, cap_en, cpu_en}, 32'd0);

        // R8 then R7: capture strobe, processor waits behind capture write
        step(1'b1, 8'hA5, 1'b0, 1'b0, 16'h0, 8'h0, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b1, 16'h1234, 8'h5A, 1'b0, 1'b0);
        chk("R8 not yet", {31'd0, cap_en}, 32'd0);
        step(1'b1, 8'h3C, 1'b1, 1'b1, 16'h1234, 8'h5A, 1'b1, 1'b0);
        chk("R8 cap_en second cycle", {31'd0, cap_en}, 32'd1);
        chk("R5 cap data", {24'd0, mem_wdata}, 32'hA5);
        step(1'b0, 8'h00, 1'b1, 1'b1, 16'h1234, 8'h5A, 1'b1, 1'b0);
        chk("R7 cpu granted before waiting byte", {31'd0, cpu_en}, 32'd1);
        chk("R2 step", {16'd0, cap_addr}, 32'd1);
        idle(1'b0);
        chk("R8 waiting capture next", {31'd0, cap_en}, 32'd1);
        chk("R5 second byte", {24'd0, mem_wdata}, 32'h3C);

        // R6: clear beats a same-cycle increment
        step(1'b0, 8'h00, 1'b0, 1'b0, 16'h0, 8'h0, 1'b1, 1'b1);
        idle(1'b0);
        chk("R6 clear wins", {16'd0, cap_addr}, 32'd0);

        // constrained random traffic
        rq = 0; rwe = 0; ra = 0; rd = 0;
        for (int i = 0; i < 20000; i++) begin
            logic v;
            if (cpu_drop) rq = 1'b0;
            else if (!rq && ($urandom % 5 == 0)) begin
                rq = 1'b1; rwe = 1'($urandom); ra = 16'($urandom); rd = 8'($urandom);
            end
            v = !m_wait && ($urandom % 4 == 0);
            step(v, 8'($urandom), rq, rwe, ra, rd,
                 1'($urandom % 3 == 0), 1'($urandom % 64 == 0));
        end
        if (cpu_drop) rq = 1'b0;
        step(1'b0, 8'h0, rq, rwe, ra, rd, 1'b1, 1'b0);
        repeat (3) idle(1'b1);

        // R2: back-to-back capture burst through the wrap
        step(1'b0, 8'h0, 1'b0, 1'b0, 16'h0, 8'h0, 1'b0, 1'b1);
        while (!(m_cnt == 16'h0 && m_st == 1 && cap_addr == 16'hFFFF))
            step(1'b1, 8'($urandom), 1'b0, 1'b0, 16'h0, 8'h0, 1'b1, 1'b0);
        idle(1'b0);
        chk("R2 wrap to zero", {16'd0, cap_addr}, 32'd0);
        repeat (4) idle(1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule